// File: doc/BRIEF.md
# Card Slot Power-State Controller

This block is the digital controller for the supply switches of a hot-pluggable card slot. The slot has three rails: a 3.3 V primary, a 1.5 V primary and an auxiliary rail. The block takes digital flags that report whether each host input rail is good, an undervoltage flag per rail, a thermal-shutdown flag, two active-low card-detect lines, an active-low shutdown request and an active-low standby request. Every one of these inputs passes through a synchronizer. The block then drives, for each rail, a switch enable and an output discharge enable, along with a 3-bit mode code.

The controller keeps a history bit that records whether the present card has been fully powered. When the primaries fall away or standby is requested, the card keeps its auxiliary supply only if it had already been fully powered. A card that is inserted while the primaries are missing, or while standby is requested, stays unpowered until both primaries are good and standby is released. Shutdown freezes this history, so releasing shutdown brings back the state that was in force before it. Discharge turns on only after the matching switch has been off for a parameterised gap, so no switch and its discharge path ever overlap.

Top module: `xc_slot_pwr_ctrl`

## Requirements
- R1: When the auxiliary input is not good (`aux_ok`=0 or `uv_aux`=1), all switch and discharge enables are 0 and `mode` is 0 (OFF). The same outputs apply while `rst_n` is low.
- R2: A card counts as present when `cp_a_n` or `cp_b_n` is low. It counts as absent only when both lines are high.
- R3: With the auxiliary input good, shutdown and thermal inactive and no card present, all switches are off, all discharge enables are on and `mode` is 3 (NOCARD).
- R4: With a card present, both primaries good (good flag 1 and undervoltage flag 0 on each) and `stby_n` high, all three switches are on, discharge is off and `mode` is 6 (FULL).
- R5: If `stby_n` goes low while the card is in FULL, only `sw_aux` stays on and `mode` is 5 (STANDBY). Releasing standby returns the card to FULL.
- R6: If either primary stops being good while the card is in FULL, the card enters STANDBY (mode 5) with auxiliary only. This covers a dropped good flag and a raised `uv_p33` or `uv_p15`.
- R7: A card inserted while a primary is not good or while `stby_n` is low gets no power and no discharge, and `mode` is 4 (UNPOWERED). When both primaries are good and standby is released, the card goes to FULL.
- R8: With `shdn_n` low (and the auxiliary input good and thermal inactive), all switches are off, all discharge enables are on and `mode` is 2 (SHUTDOWN). Releasing shutdown restores the mode and switch pattern held before it.
- R9: A discharge enable rises only after its own switch has been off for at least `BBM_CYCLES` cycles; with the default of 2, the rise comes exactly 3 cycles after the switch falls. A switch and its discharge enable are never both on.
- R10: While `ot_flag` is high (and the auxiliary input is good), all switch and discharge enables are 0 and `mode` is 1 (HOT). When the flag clears, the rules above apply again, and a fully powered card returns to FULL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aux_ok | input | 1 | Auxiliary input rail good |
| p33_ok | input | 1 | 3.3 V input rail good |
| p15_ok | input | 1 | 1.5 V input rail good |
| uv_aux | input | 1 | Auxiliary undervoltage flag |
| uv_p33 | input | 1 | 3.3 V undervoltage flag |
| uv_p15 | input | 1 | 1.5 V undervoltage flag |
| ot_flag | input | 1 | Thermal shutdown flag |
| cp_a_n | input | 1 | Card-detect line A, active low |
| cp_b_n | input | 1 | Card-detect line B, active low |
| shdn_n | input | 1 | Shutdown request, active low |
| stby_n | input | 1 | Standby request, active low |
| sw_aux | output | 1 | Auxiliary switch enable |
| sw_p33 | output | 1 | 3.3 V switch enable |
| sw_p15 | output | 1 | 1.5 V switch enable |
| dis_aux | output | 1 | Auxiliary output discharge enable |
| dis_p33 | output | 1 | 3.3 V output discharge enable |
| dis_p15 | output | 1 | 1.5 V output discharge enable |
| mode | output | 3 | Mode: 0 OFF, 1 HOT, 2 SHUTDOWN, 3 NOCARD, 4 UNPOWERED, 5 STANDBY, 6 FULL |

## Verification
The assertions check on every cycle that the switch pattern agrees with the reported mode. They check that primary switches are on only in FULL, that no switch is on in OFF, HOT, SHUTDOWN or UNPOWERED, that no switch overlaps its own discharge enable, and that each discharge rise follows at least the break-before-make gap. Behaviours that depend on history only show in the bench's sequences. These are the return to the pre-shutdown state, the choice between STANDBY and UNPOWERED on a late insertion, and recovery after a thermal event or a primary dropout. The bench also measures the exact gap between a switch falling and its discharge rising.

// File: rtl/xc_slot_pwr_ctrl.sv
module xc_slot_pwr_ctrl #(
  parameter int BBM_CYCLES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       aux_ok,
  input  logic       p33_ok,
  input  logic       p15_ok,
  input  logic       uv_aux,
  input  logic       uv_p33,
  input  logic       uv_p15,
  input  logic       ot_flag,
  input  logic       cp_a_n,
  input  logic       cp_b_n,
  input  logic       shdn_n,
  input  logic       stby_n,
  output logic       sw_aux,
  output logic       sw_p33,
  output logic       sw_p15,
  output logic       dis_aux,
  output logic       dis_p33,
  output logic       dis_p15,
  output logic [2:0] mode
);

  localparam int NIN = 11;
  localparam int CW  = $clog2(BBM_CYCLES + 2);
  localparam logic [NIN-1:0] RST_PAT = 11'b000_0000_1111;

  localparam logic [2:0] M_OFF  = 3'd0;
  localparam logic [2:0] M_HOT  = 3'd1;
  localparam logic [2:0] M_SHDN = 3'd2;
  localparam logic [2:0] M_NOCD = 3'd3;
  localparam logic [2:0] M_UNPW = 3'd4;
  localparam logic [2:0] M_STBY = 3'd5;
  localparam logic [2:0] M_FULL = 3'd6;

  logic [NIN-1:0] raw, s;
  logic [NIN-1:0] sync_q [SYNC_STAGES];

  assign raw = {aux_ok, p33_ok, p15_ok, uv_aux, uv_p33, uv_p15, ot_flag,
                cp_a_n, cp_b_n, shdn_n, stby_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= RST_PAT;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign s = sync_q[SYNC_STAGES-1];

  logic aux_good, prim_good, card, hot, shdn_req, stby_req;
  assign aux_good  = s[10] & ~s[7];
  assign prim_good = s[9] & s[8] & ~s[6] & ~s[5];
  assign hot       = s[4];
  assign card      = ~(s[3] & s[2]);
  assign shdn_req  = ~s[1];
  assign stby_req  = ~s[0];

  logic       hist_q;
  logic [2:0] tgt, mode_q;

  always_comb begin
    if (!aux_good)                  tgt = M_OFF;
    else if (hot)                   tgt = M_HOT;
    else if (shdn_req)              tgt = M_SHDN;
    else if (!card)                 tgt = M_NOCD;
    else if (prim_good && !stby_req) tgt = M_FULL;
    else if (hist_q)                tgt = M_STBY;
    else                            tgt = M_UNPW;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      mode_q <= M_OFF;
    end else begin
      mode_q <= tgt;
      if (!aux_good || !card) hist_q <= 1'b0;
      else if (tgt == M_FULL) hist_q <= 1'b1;
    end
  end

  logic [2:0] sw_tgt, sw_q, dis_q;
  logic       dis_tgt;

  assign sw_tgt  = {tgt == M_FULL, tgt == M_FULL, (tgt == M_FULL) || (tgt == M_STBY)};
  assign dis_tgt = (tgt == M_SHDN) || (tgt == M_NOCD);

  for (genvar r = 0; r < 3; r++) begin : g_rail
    logic [CW-1:0] off_cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sw_q[r]  <= 1'b0;
        dis_q[r] <= 1'b0;
        off_cnt  <= '0;
      end else begin
        sw_q[r]  <= sw_tgt[r] & ~dis_q[r];
        dis_q[r] <= dis_tgt & ~sw_q[r] & ~sw_tgt[r] & (off_cnt == CW'(BBM_CYCLES));
        if (sw_q[r])                          off_cnt <= '0;
        else if (off_cnt != CW'(BBM_CYCLES))  off_cnt <= off_cnt + 1'b1;
      end
    end
  end

  assign {sw_p33, sw_p15, sw_aux}    = {sw_q[2], sw_q[1], sw_q[0]};
  assign {dis_p33, dis_p15, dis_aux} = {dis_q[2], dis_q[1], dis_q[0]};
  assign mode = mode_q;

endmodule

// File: rtl/xc_slot_pwr_ctrl_chk.sv
module xc_slot_pwr_ctrl_chk #(
  parameter int BBM_CYCLES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_aux,
  input logic       sw_p33,
  input logic       sw_p15,
  input logic       dis_aux,
  input logic       dis_p33,
  input logic       dis_p15,
  input logic [2:0] mode
);

  logic [7:0] off_a, off_3, off_1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_a <= '0; off_3 <= '0; off_1 <= '0;
    end else begin
      off_a <= sw_aux ? 8'd0 : (off_a == 8'hff ? off_a : off_a + 8'd1);
      off_3 <= sw_p33 ? 8'd0 : (off_3 == 8'hff ? off_3 : off_3 + 8'd1);
      off_1 <= sw_p15 ? 8'd0 : (off_1 == 8'hff ? off_1 : off_1 + 8'd1);
    end
  end

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd0 |-> !(sw_aux | sw_p33 | sw_p15 | dis_aux | dis_p33 | dis_p15));

  a_r4_primaries_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_p33 | sw_p15) |-> mode == 3'd6);

  a_r5_standby_aux_only: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd5 |-> !sw_p33 && !sw_p15 && !dis_aux);

  a_r7_unpowered_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd4 |-> !(sw_aux | sw_p33 | sw_p15 | dis_aux | dis_p33 | dis_p15));

  a_r8_shutdown_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd2 |-> !(sw_aux | sw_p33 | sw_p15));

  a_r10_hot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd1 |-> !(sw_aux | sw_p33 | sw_p15 | dis_aux | dis_p33 | dis_p15));

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !((sw_aux & dis_aux) | (sw_p33 & dis_p33) | (sw_p15 & dis_p15)));

  a_r9_gap_aux: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_aux) |-> off_a >= 8'(BBM_CYCLES));

  a_r9_gap_p33: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_p33) |-> off_3 >= 8'(BBM_CYCLES));

  a_r9_gap_p15: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_p15) |-> off_1 >= 8'(BBM_CYCLES));

endmodule

bind xc_slot_pwr_ctrl xc_slot_pwr_ctrl_chk #(.BBM_CYCLES(BBM_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sw_aux(sw_aux), .sw_p33(sw_p33), .sw_p15(sw_p15),
  .dis_aux(dis_aux), .dis_p33(dis_p33), .dis_p15(dis_p15),
  .mode(mode)
);

// File: tb/tb_xc_slot_pwr_ctrl.sv
module tb_xc_slot_pwr_ctrl;
  logic clk = 0, rst_n = 0;
  logic aux_ok, p33_ok, p15_ok, uv_aux, uv_p33, uv_p15, ot_flag;
  logic cp_a_n, cp_b_n, shdn_n, stby_n;
  logic sw_aux, sw_p33, sw_p15, dis_aux, dis_p33, dis_p15;
  logic [2:0] mode;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xc_slot_pwr_ctrl dut (.*);

  // inputs: aux p33 p15 uvA uv33 uv15 ot | cpa_n cpb_n shdn_n stby_n
  // expect: sw_aux sw33 sw15 | dis_aux dis33 dis15 | mode
  localparam int NV = 29;
  localparam logic [19:0] VEC [NV] = '{
    20'b0110000_1111_000_000_000, // R1 aux absent
    20'b1110000_1111_000_111_011, // R3 no card
    20'b1110000_0111_111_000_110, // R2 R4 line A
    20'b1110000_1011_111_000_110, // R2 line B
    20'b1110000_1010_100_000_101, // R5 standby
    20'b1110000_1011_111_000_110, // R5 release
    20'b1010000_1011_100_000_101, // R6 3.3 drop
    20'b1110000_1011_111_000_110, // R6 back
    20'b1110010_1011_100_000_101, // R6 uv 1.5
    20'b1110000_1011_111_000_110, // R6 clear
    20'b1110000_1001_000_111_010, // R8 shutdown
    20'b1110000_1011_111_000_110, // R8 restore full
    20'b1110000_1010_100_000_101, // R5 standby
    20'b1110000_1000_000_111_010, // R8 shutdown from standby
    20'b1110000_1010_100_000_101, // R8 restore standby
    20'b1110000_1011_111_000_110, // R5 release
    20'b1110001_1011_000_000_001, // R10 thermal
    20'b1110000_1011_111_000_110, // R10 recover
    20'b1111000_1011_000_000_000, // R1 aux uv
    20'b1110000_1011_111_000_110, // R4 aux back
    20'b1110000_1111_000_111_011, // R2 R3 both lines high
    20'b1100000_1111_000_111_011, // R3 1.5 missing
    20'b1100000_0111_000_000_100, // R7 late insert
    20'b1110000_0111_111_000_110, // R7 prim returns
    20'b1110000_1111_000_111_011, // R3 removed
    20'b1110000_1110_000_111_011, // R3 standby no card
    20'b1110000_0110_000_000_100, // R7 insert in standby
    20'b1110000_0111_111_000_110, // R7 release
    20'b0110000_0111_000_000_000  // R1 aux gone
  };

  function automatic string tag_of(int i);
    case (i)
      0, 18, 28:                  return "R1";
      2, 3, 19:                   return "R4";
      20:                         return "R2";
      1, 21, 24, 25:              return "R3";
      4, 5, 12, 15:               return "R5";
      6, 7, 8, 9:                 return "R6";
      10, 11, 13, 14:             return "R8";
      16, 17:                     return "R10";
      default:                    return "R7";
    endcase
  endfunction

  task automatic apply(input logic [10:0] v);
    {aux_ok, p33_ok, p15_ok, uv_aux, uv_p33, uv_p15, ot_flag,
     cp_a_n, cp_b_n, shdn_n, stby_n} = v;
  endtask

  task automatic check(input string tag, input logic [8:0] exp);
    logic [8:0] act;
    act = {sw_aux, sw_p33, sw_p15, dis_aux, dis_p33, dis_p15, mode};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    apply(11'b1110000_0111);
    repeat (4) @(negedge clk);
    check("R1 reset", 9'b000_000_000);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i][19:9]);
      repeat (12) @(negedge clk);
      check(tag_of(i), VEC[i][8:0]);
    end

    // R9: exact break-before-make gap on card removal from FULL
    apply(11'b1110000_0111);
    repeat (12) @(negedge clk);
    check("R9 setup", 9'b111_000_110);
    apply(11'b1110000_1111);
    begin
      int t_off = -1, t_dis = -1;
      bit overlap = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (t_off < 0 && !sw_aux) t_off = c;
        if (t_dis < 0 && dis_aux) t_dis = c;
        if ((sw_aux & dis_aux) | (sw_p33 & dis_p33) | (sw_p15 & dis_p15)) overlap = 1;
      end
      checks++;
      if (t_off < 0 || t_dis - t_off != 3) begin
        errors++;
        $display("FAIL R9 gap: got %0d expected 3", t_dis - t_off);
      end
      checks++;
      if (overlap) begin
        errors++;
        $display("FAIL R9 overlap: got 1 expected 0");
      end
    end

    // R9: switch returns only after discharge drops on reinsertion
    apply(11'b1110000_1011);
    begin
      bit overlap = 0;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        if (sw_aux & dis_aux) overlap = 1;
      end
      checks++;
      if (overlap) begin
        errors++;
        $display("FAIL R9 reinsertion overlap: got 1 expected 0");
      end
      check("R9 reinsert full", 9'b111_000_110);
    end

    // R1: reset in the middle of FULL clears everything
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 mid reset", 9'b000_000_000);
    rst_n = 1;
    repeat (12) @(negedge clk);
    check("R4 after reset", 9'b111_000_110);

    finish_run();
  end
endmodule